// File: doc/BRIEF.md
# Window-Gated Trigger Delay Unit

This block sits between an external time-of-flight trigger source and the front-end boards. It rebuilds the board's periodic live integration windows from a frame-sync reference. It also produces a second window, the valid-particle window, which is the same pattern moved later by a programmable offset so that it covers cable and waveguide delay. The offset can be swept during calibration until the window lines up with real particle arrivals.

A trigger that arrives while the valid-particle window is high is accepted. All other triggers are vetoed. Each accepted trigger is stored as a timestamp in a queue, so several can be in flight at once. It leaves as an L1 accept exactly `depth*PERIOD + cable` cycles later. `depth` is the programmable analog pipeline depth in samples and `cable` is a latency in cycles. If that landing cycle falls between live windows, the L1 accept is held until the next live cycle and a misalignment flag is raised with it. Two saturating counters record accepted and vetoed triggers.

A three-state scheduler serves the head of the queue. **Idle** means the queue is empty. **Wait** means the head is not yet due. **Snap** means the head is due but the current cycle is outside a live window. The transitions are:
- *arm*: Idle to Wait, when the queue becomes non-empty.
- *late*: Wait to Snap, when the head is due in a dead cycle.
- *fire-more*: Wait or Snap to Wait, when an L1 accept leaves and entries remain.
- *fire-last*: Wait or Snap to Idle, when an L1 accept leaves and the queue empties.

Top module: `trig_window_delay`

## Requirements
- R1: After reset, `l1a_o` and `misalign_o` are low and both counters read zero.
- R2: The cycle after a cycle with `frame_sync_i` high is phase 0. The phase then counts 0..PERIOD-1 and wraps. `live_win_o` is high exactly in phases 0..LIVE_W-1.
- R3: `valid_win_o` is high in a cycle whose phase is p exactly when `(p - cfg_offset_i) mod PERIOD < LIVE_W`. This is the live pattern delayed by the offset. The offset must be below PERIOD.
- R4: A trigger high in one cycle is accepted only if `valid_win_o` is high in that cycle. A trigger outside the window produces no L1 accept.
- R5: An accepted trigger in cycle c has landing cycle c+D, where D = depth*PERIOD + `cfg_cable_i`. If the landing cycle is live and no earlier L1 accept is still pending, `l1a_o` is high for one cycle exactly at c+D and `misalign_o` is low.
- R6: If the landing cycle is not live, `l1a_o` is high at the first live cycle after it, and `misalign_o` is high in that same cycle.
- R7: Several accepted triggers may be in flight. They leave in order, at most one per cycle. Each leaves at the first live cycle that is not before its landing cycle and follows the previous L1 accept. `misalign_o` is high whenever an L1 accept leaves later than its landing cycle.
- R8: A depth of 0 is treated as 1. A depth above MAX_DEPTH is treated as MAX_DEPTH.
- R9: `acc_count_o` counts accepted triggers and `veto_count_o` counts rejected ones. Both stop at their all-ones value.
- R10: When QDEPTH triggers are already in flight, a further trigger is dropped even inside the window, and it is counted as a veto.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync_i | input | 1 | Timing reference; restarts the window phase |
| tof_trig_i | input | 1 | External trigger, one pulse per cycle high |
| cfg_offset_i | input | $clog2(PERIOD) | Valid-window delay in cycles |
| cfg_depth_i | input | $clog2(MAX_DEPTH+1) | Pipeline depth in samples |
| cfg_cable_i | input | CAB_W | Extra latency in cycles |
| live_win_o | output | 1 | Live integration window |
| valid_win_o | output | 1 | Offset valid-particle window |
| l1a_o | output | 1 | Delayed L1 accept pulse |
| misalign_o | output | 1 | L1 accept left later than its landing cycle |
| acc_count_o | output | CNT_W | Saturating accepted-trigger count |
| veto_count_o | output | CNT_W | Saturating vetoed-trigger count |

## Verification
The hardest situations to reach from the ports involve several entries interacting. One is an entry that becomes due while an earlier, snapped L1 accept is still waiting. The other is a full queue. Both need bursts of triggers on consecutive live cycles, with a cable latency chosen so that the landings straddle the end of a window. The bench uses a short period and a four-entry queue, so these bursts can be placed precisely. A cycle-level model in the bench predicts every leave cycle and flag, and it tracks queue occupancy. Single triggers are also swept over every offset, every trigger phase and several depth and cable settings.

// File: rtl/twd_pkg.sv
package twd_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_SNAP = 2'd2
    } sched_state_t;
endpackage

// File: rtl/twd_phase_gen.sv
module twd_phase_gen #(
    parameter int PERIOD = 81,
    parameter int LIVE_W = 20,
    parameter int PH_W   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_i,
    input  logic [PH_W-1:0] offset_i,
    output logic            live_o,
    output logic            valid_o
);
    localparam logic [PH_W:0] PER_X  = (PH_W+1)'(PERIOD);
    localparam logic [PH_W:0] LIVE_X = (PH_W+1)'(LIVE_W);
    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    logic [PH_W-1:0] phase;
    logic [PH_W:0]   shifted;

    always_ff @(posedge clk) begin
        if (!rst_n)              phase <= '0;
        else if (sync_i)         phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
    end

    always_comb begin
        if ({1'b0, offset_i} <= {1'b0, phase})
            shifted = {1'b0, phase} - {1'b0, offset_i};
        else
            shifted = {1'b0, phase} + PER_X - {1'b0, offset_i};
    end

    assign live_o  = ({1'b0, phase} < LIVE_X);
    assign valid_o = (shifted < LIVE_X);

    // R2
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (phase == '0));
    // R3
    offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, offset_i} < PER_X));
endmodule

// File: rtl/twd_due_queue.sv
module twd_due_queue #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [W-1:0]  data_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;

    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (push_i) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_i)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({push_i, pop_i})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr];
    assign full_o  = (count_o == CW'(DEPTH));
    assign empty_o = (count_o == '0);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (count_o < CW'(DEPTH)));
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/twd_sat_counter.sv
module twd_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)                      count_o <= '0;
        else if (inc_i && count_o != TOP) count_o <= count_o + 1'b1;
    end

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == TOP) |=> (count_o == TOP));
    // R9
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && count_o != TOP) |=> (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/trig_window_delay.sv
module trig_window_delay
    import twd_pkg::*;
#(
    parameter int PERIOD    = 81,
    parameter int LIVE_W    = 20,
    parameter int MAX_DEPTH = 48,
    parameter int CAB_W     = 8,
    parameter int CNT_W     = 16,
    parameter int QDEPTH    = 64,
    localparam int PH_W     = $clog2(PERIOD),
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_sync_i,
    input  logic               tof_trig_i,
    input  logic [PH_W-1:0]    cfg_offset_i,
    input  logic [DEPTH_W-1:0] cfg_depth_i,
    input  logic [CAB_W-1:0]   cfg_cable_i,
    output logic               live_win_o,
    output logic               valid_win_o,
    output logic               l1a_o,
    output logic               misalign_o,
    output logic [CNT_W-1:0]   acc_count_o,
    output logic [CNT_W-1:0]   veto_count_o
);
    localparam int SPAN = MAX_DEPTH * PERIOD + (1 << CAB_W) + QDEPTH + PERIOD;
    localparam int TS_W = $clog2(SPAN) + 2;
    localparam int QCW  = $clog2(QDEPTH + 1);
    localparam logic [DEPTH_W-1:0] DEP_MAX = DEPTH_W'(MAX_DEPTH);

    sched_state_t state, state_nxt;

    logic [TS_W-1:0]    ts;
    logic [DEPTH_W-1:0] eff_depth;
    logic [TS_W-1:0]    delay_cyc, due_in, q_head, lag;
    logic [QCW-1:0]     q_count;
    logic               q_full, q_empty, q_push, q_pop;
    logic               veto, reached, fire, more;
    logic [1:0]         cnt_inc;
    logic [CNT_W-1:0]   cnt_val [2];

    twd_phase_gen #(.PERIOD(PERIOD), .LIVE_W(LIVE_W), .PH_W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (frame_sync_i),
        .offset_i (cfg_offset_i),
        .live_o   (live_win_o),
        .valid_o  (valid_win_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + 1'b1;
    end

    always_comb begin
        if (cfg_depth_i == '0)         eff_depth = DEPTH_W'(1);
        else if (cfg_depth_i > DEP_MAX) eff_depth = DEP_MAX;
        else                           eff_depth = cfg_depth_i;
    end

    assign delay_cyc = TS_W'(eff_depth) * TS_W'(PERIOD) + TS_W'(cfg_cable_i);
    assign due_in    = ts + delay_cyc;
    assign q_push    = tof_trig_i && valid_win_o && !q_full;
    assign veto      = tof_trig_i && !q_push;

    twd_due_queue #(.DEPTH(QDEPTH), .W(TS_W), .CW(QCW)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (q_push),
        .pop_i   (q_pop),
        .data_i  (due_in),
        .head_o  (q_head),
        .count_o (q_count),
        .full_o  (q_full),
        .empty_o (q_empty)
    );

    assign lag     = ts - q_head;
    assign reached = !lag[TS_W-1];
    assign more    = (q_count > QCW'(1)) || q_push;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (!q_empty) state_nxt = S_WAIT;
            S_WAIT: begin
                if (fire)         state_nxt = more ? S_WAIT : S_IDLE;
                else if (reached) state_nxt = S_SNAP;
            end
            S_SNAP: if (fire) state_nxt = more ? S_WAIT : S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fire       = (state != S_IDLE) && reached && live_win_o;
        q_pop      = fire;
        l1a_o      = fire;
        misalign_o = fire && (lag != '0);
    end

    assign cnt_inc = {veto, q_push};

    for (genvar i = 0; i < 2; i++) begin : g_cnt
        twd_sat_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (cnt_inc[i]),
            .count_o (cnt_val[i])
        );
    end

    assign acc_count_o  = cnt_val[0];
    assign veto_count_o = cnt_val[1];

    // R7
    pop_in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l1a_o && !q_push) |=> (q_count == $past(q_count) - 1'b1));
    // R6
    snap_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SNAP && !live_win_o) |=> (state == S_SNAP));
    // R9
    one_bucket_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tof_trig_i && acc_count_o != '1 && veto_count_o != '1) |=>
        ((acc_count_o != $past(acc_count_o)) != (veto_count_o != $past(veto_count_o))));
    // R4
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tof_trig_i |=> ($stable(acc_count_o) && $stable(veto_count_o)));
endmodule

// File: tb/sim_trig_window_delay.sv
`timescale 1ns/1ps
module sim_trig_window_delay;
    localparam int P = 8, LW = 3, MD = 4, CABW = 3, NW = 4, QD = 4;

    logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, trig = 1'b0;
    logic [2:0] off = '0, dep = 3'd1;
    logic [CABW-1:0] cab = '0;
    logic live_w, valid_w, l1a, mis;
    logic [NW-1:0] acc_c, veto_c;

    always #2 clk = ~clk;

    trig_window_delay #(.PERIOD(P), .LIVE_W(LW), .MAX_DEPTH(MD), .CAB_W(CABW),
                        .CNT_W(NW), .QDEPTH(QD)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync_i(fsync), .tof_trig_i(trig),
        .cfg_offset_i(off), .cfg_depth_i(dep), .cfg_cable_i(cab),
        .live_win_o(live_w), .valid_win_o(valid_w), .l1a_o(l1a),
        .misalign_o(mis), .acc_count_o(acc_c), .veto_count_o(veto_c));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0, c0 = 0;
    int exp_t[64], exp_push[64], obs_t[64];
    bit exp_m[64], obs_m[64];
    int exp_n = 0, obs_n = 0, m_acc = 0, m_veto = 0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (rst_n && l1a) begin
            if (obs_n < 64) begin
                obs_t[obs_n] = cyc;
                obs_m[obs_n] = mis;
            end
            obs_n++;
        end
    end

    function automatic int modp(int x);
        int r = x % P;
        if (r < 0) r += P;
        return r;
    endfunction
    function automatic bit m_live(int t);
        return modp(t - c0 - 1) < LW;
    endfunction
    function automatic bit m_valid(int t);
        return modp(t - c0 - 1 - int'(off)) < LW;
    endfunction
    function automatic int m_delay();
        int d = int'(dep);
        if (d == 0) d = 1;
        if (d > MD) d = MD;
        return d * P + int'(cab);
    endfunction
    function automatic int sat(int x);
        return (x > (1 << NW) - 1) ? (1 << NW) - 1 : x;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; trig = 1'b0; fsync = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fsync = 1'b1; c0 = cyc;
        @(negedge clk);
        fsync = 1'b0;
        exp_n = 0; obs_n = 0; m_acc = 0; m_veto = 0;
    endtask

    task automatic wait_phase(input int tp);
        while (modp(cyc - c0 - 1) != tp) @(negedge clk);
    endtask

    task automatic drive_trig();
        int c = cyc;
        int occ = 0;
        for (int k = 0; k < exp_n; k++)
            if (exp_push[k] < c && exp_t[k] >= c) occ++;
        if (m_valid(c) && occ < QD) begin
            int due = c + m_delay();
            int t = due;
            if (exp_n > 0 && t < exp_t[exp_n-1] + 1) t = exp_t[exp_n-1] + 1;
            while (!m_live(t)) t++;
            exp_push[exp_n] = c; exp_t[exp_n] = t; exp_m[exp_n] = (t != due);
            exp_n++; m_acc++;
        end else begin
            m_veto++;
        end
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic drain_compare(input string req);
        repeat (MD * P + 8 + P + QD + 4) @(negedge clk);
        chk(obs_n == exp_n, req, "L1 accept count", obs_n, exp_n);
        for (int i = 0; i < exp_n && i < obs_n; i++) begin
            chk(obs_t[i] == exp_t[i], exp_m[i] ? "R6" : "R5", "L1 accept cycle",
                obs_t[i], exp_t[i]);
            chk(obs_m[i] == exp_m[i], exp_m[i] ? "R6" : "R5", "misalign flag",
                int'(obs_m[i]), int'(exp_m[i]));
        end
        chk(int'(acc_c) == sat(m_acc), "R9", "accepted count", int'(acc_c), sat(m_acc));
        chk(int'(veto_c) == sat(m_veto), "R9", "veto count", int'(veto_c), sat(m_veto));
        exp_n = 0; obs_n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int tcyc;
        do_reset();
        // R1 reset state
        chk(l1a == 1'b0, "R1", "l1a after reset", int'(l1a), 0);
        chk(mis == 1'b0, "R1", "misalign after reset", int'(mis), 0);
        chk(acc_c == '0, "R1", "accepted after reset", int'(acc_c), 0);
        chk(veto_c == '0, "R1", "veto after reset", int'(veto_c), 0);

        // R2 live window pattern
        for (int i = 0; i < 3 * P; i++) begin
            chk(live_w == m_live(cyc), "R2", "live window", int'(live_w), int'(m_live(cyc)));
            @(negedge clk);
        end

        // R3 valid window for every offset
        for (int o = 0; o < P; o++) begin
            off = 3'(o);
            @(negedge clk);
            for (int i = 0; i < P; i++) begin
                chk(valid_w == m_valid(cyc), "R3", "valid window", int'(valid_w),
                    int'(m_valid(cyc)));
                @(negedge clk);
            end
        end

        // R4 R5 R6 single-trigger sweep
        for (int d = 1; d <= 2; d++) begin
            for (int ci = 0; ci < 3; ci++) begin
                for (int o = 0; o < P; o++) begin
                    for (int tp = 0; tp < P; tp++) begin
                        dep = 3'(d); cab = CABW'(ci * 3); off = 3'(o);
                        wait_phase(tp);
                        drive_trig();
                        drain_compare("R4");
                    end
                end
            end
        end

        // R8 depth clamping
        off = '0; cab = CABW'(2);
        dep = 3'd0;
        wait_phase(0);
        tcyc = cyc;
        drive_trig();
        drain_compare("R8");
        chk(m_delay() == P + 2, "R8", "depth 0 model delay", m_delay(), P + 2);
        dep = 3'd0;
        wait_phase(0);
        tcyc = cyc;
        drive_trig();
        repeat (MD * P + 8 + P + QD + 4) @(negedge clk);
        chk(obs_n == 1 && obs_t[0] - tcyc == P + 2, "R8", "depth 0 latency",
            obs_t[0] - tcyc, P + 2);
        exp_n = 0; obs_n = 0;
        dep = 3'd7;
        wait_phase(0);
        tcyc = cyc;
        drive_trig();
        repeat (MD * P + 8 + P + QD + 4) @(negedge clk);
        chk(obs_n == 1 && obs_t[0] - tcyc == MD * P + 2, "R8", "depth over max latency",
            obs_t[0] - tcyc, MD * P + 2);
        exp_n = 0; obs_n = 0;

        // R7 bursts: landing straddles the window end
        dep = 3'd1; off = '0;
        for (int ci = 1; ci <= 2; ci++) begin
            cab = CABW'(ci);
            wait_phase(0);
            for (int k = 0; k < 3; k++) drive_trig();
            chk(exp_n == 3, "R7", "burst accepted in model", exp_n, 3);
            drain_compare("R7");
        end

        // R10 queue full drops and counts as veto
        do_reset();
        dep = 3'd4; cab = '0; off = '0;
        wait_phase(0);
        for (int k = 0; k < 3; k++) drive_trig();
        wait_phase(0);
        for (int k = 0; k < 3; k++) drive_trig();
        @(negedge clk);
        chk(acc_c == NW'(4), "R10", "accepted with full queue", int'(acc_c), 4);
        chk(veto_c == NW'(2), "R10", "vetoed with full queue", int'(veto_c), 2);
        drain_compare("R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule